// File: doc/BRIEF.md
# Quasi-Bidirectional GPIO Pin Controller

This block is the digital control for an 8-pin general-purpose I/O port. For every pin it takes a 2-bit mode, an output data bit, a slew-rate select and the raw pad level. From these it produces the enables for the pad's low-side driver and for three pull-up transistors of graded strength: very weak, weak and strong. It also produces the per-pin slew select and a synchronized readback of the pad.

The mode, data and slew inputs are captured into per-pin configuration flops on every clock. The outputs are decoded from those flops, so every output follows its input one clock later. Reset puts all pins into quasi-bidirectional mode with the data latch at 1. The port therefore comes up weakly pulled high and can still be driven from outside.

In quasi-bidirectional mode, a 0 in the latch drives the pad low. A 1 in the latch releases the pad to the pull-ups, and any outside driver can override them. When the latch moves from 0 to 1, the strong pull-up turns on for exactly two clocks to speed up the rising edge. The pad level can always be read back, whatever the mode.

Top module: `qbio_port`

## Requirements
- R1: Reset puts every pin in quasi-bidirectional mode with latch 1 and both synchronizer flops at 1, and sets the slew select to 0. While reset is held, the outputs are: pull-down enable 0, very weak enable all ones, weak enable all ones, strong enable 0, readback all ones, slew select 0.
- R2: Pin i uses mode bits mode_i[2i+1:2i], with 00 quasi-bidirectional, 01 push-pull, 10 input-only and 11 open-drain. One clock after a pin's latch input is 0 in any mode except input-only, its pull-down enable is 1. In every other case the pull-down enable is 0.
- R3: In quasi-bidirectional mode, the very weak pull-up enable equals the registered latch. In every other mode it is 0.
- R4: In quasi-bidirectional mode with the registered latch at 1, the weak pull-up enable equals the synchronized readback of that pin. Otherwise it is 0. An outside low on the pad therefore turns the weak pull-up off two clocks later.
- R5: In quasi-bidirectional mode, the strong pull-up turns on for exactly two clocks when the latch changes from 0 to 1. These are the first two clock periods after the edge that captures the 1. The boost stops early if the latch or the mode changes.
- R6: The readback output equals the pad input delayed by two flops, in every mode.
- R7: The slew select output equals the slew input captured at the previous clock edge, independently per pin.
- R8: In push-pull mode, the strong pull-up enable equals the registered latch. The weak and very weak enables are 0.
- R9: In input-only and open-drain modes, no pull-up enable is ever 1. Input-only also keeps the pull-down enable at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2*NPINS | Per-pin mode, 2 bits per pin |
| latch_i | input | NPINS | Per-pin output data latch value |
| slew_i | input | NPINS | Per-pin slew-rate select |
| pad_i | input | NPINS | Raw pad level, asynchronous |
| pd_en_o | output | NPINS | Low-side driver enable |
| pu_strong_o | output | NPINS | Strong pull-up enable |
| pu_weak_o | output | NPINS | Weak pull-up enable |
| pu_vweak_o | output | NPINS | Very weak pull-up enable |
| slew_o | output | NPINS | Registered slew-rate select |
| rd_o | output | NPINS | Synchronized pad readback |

## Verification
The assertions assume that the mode, latch and slew inputs are sampled at the rising clock edge. They do not assume that the pad input has any relationship to the driver enables, because an outside source may pull the pad either way in any mode. The assertions that look back in time stay inactive until enough clocks have passed since reset to cover their depth, so the values captured before reset cannot affect them. The stimulus changes inputs only at the falling edge. It covers fixed mode and latch sequences, outside pull-downs during quasi-bidirectional operation, mode changes during a boost, and pseudo-random mixes across all four modes.

// File: rtl/qbio_port.sv
module qbio_port #(
  parameter int NPINS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*NPINS-1:0] mode_i,
  input  logic [NPINS-1:0]   latch_i,
  input  logic [NPINS-1:0]   slew_i,
  input  logic [NPINS-1:0]   pad_i,
  output logic [NPINS-1:0]   pd_en_o,
  output logic [NPINS-1:0]   pu_strong_o,
  output logic [NPINS-1:0]   pu_weak_o,
  output logic [NPINS-1:0]   pu_vweak_o,
  output logic [NPINS-1:0]   slew_o,
  output logic [NPINS-1:0]   rd_o
);
  localparam int BOOST_CYCLES = 2;
  localparam int CW = $clog2(BOOST_CYCLES + 1);
  localparam logic [1:0] M_QB = 2'b00;
  localparam logic [1:0] M_PP = 2'b01;
  localparam logic [1:0] M_IN = 2'b10;

  logic [2*NPINS-1:0] mode_q;
  logic [NPINS-1:0]   latch_q, slew_q, sync1_q, sync2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= '0;
      latch_q <= '1;
      slew_q  <= '0;
      sync1_q <= '1;
      sync2_q <= '1;
    end else begin
      mode_q  <= mode_i;
      latch_q <= latch_i;
      slew_q  <= slew_i;
      sync1_q <= pad_i;
      sync2_q <= sync1_q;
    end
  end

  assign slew_o = slew_q;
  assign rd_o   = sync2_q;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic [1:0]    md, md_nxt;
    logic [CW-1:0] boost_q;
    logic          is_qb, rise_nxt;

    assign md       = mode_q[2*i +: 2];
    assign md_nxt   = mode_i[2*i +: 2];
    assign is_qb    = (md == M_QB);
    assign rise_nxt = latch_i[i] && !latch_q[i] && (md_nxt == M_QB);

    always_ff @(posedge clk) begin
      if (!rst_n)
        boost_q <= '0;
      else if (rise_nxt)
        boost_q <= CW'(BOOST_CYCLES);
      else if (boost_q != '0 && latch_i[i] && md_nxt == M_QB)
        boost_q <= boost_q - 1'b1;
      else
        boost_q <= '0;
    end

    assign pd_en_o[i]     = (md != M_IN) && !latch_q[i];
    assign pu_vweak_o[i]  = is_qb && latch_q[i];
    assign pu_weak_o[i]   = is_qb && latch_q[i] && sync2_q[i];
    assign pu_strong_o[i] = latch_q[i] &&
                            ((md == M_PP) || (is_qb && boost_q != '0));
  end
endmodule

module qbio_port_chk #(
  parameter int NPINS = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2*NPINS-1:0] mode_i,
  input logic [NPINS-1:0]   latch_i,
  input logic [NPINS-1:0]   slew_i,
  input logic [NPINS-1:0]   pad_i,
  input logic [NPINS-1:0]   pd_en_o,
  input logic [NPINS-1:0]   pu_strong_o,
  input logic [NPINS-1:0]   pu_weak_o,
  input logic [NPINS-1:0]   pu_vweak_o,
  input logic [NPINS-1:0]   slew_o,
  input logic [NPINS-1:0]   rd_o
);
  logic [1:0]         age;
  logic [2*NPINS-1:0] mode_d;
  logic [NPINS-1:0]   qb_d, pp_d, off_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      age    <= '0;
      mode_d <= '0;
    end else begin
      if (age != 2'd3) age <= age + 1'b1;
      mode_d <= mode_i;
    end
  end

  always_comb begin
    for (int i = 0; i < NPINS; i++) begin
      qb_d[i]  = mode_d[2*i +: 2] == 2'b00;
      pp_d[i]  = mode_d[2*i +: 2] == 2'b01;
      off_d[i] = mode_d[2*i +: 2][1];
    end
  end

  // R2
  no_drive_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_en_o & (pu_strong_o | pu_weak_o | pu_vweak_o)) == '0);

  // R4
  weak_needs_vweak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pu_weak_o & ~pu_vweak_o) == '0);

  // R5
  boost_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    age == 2'd3 |->
      (pu_strong_o & qb_d & $past(latch_i, 2) & $past(latch_i, 3)) == '0);

  // R6
  readback_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    age >= 2'd2 |-> rd_o == $past(pad_i, 2));

  // R7
  slew_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    age >= 2'd1 |-> slew_o == $past(slew_i));

  // R8
  pp_no_soft_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pu_weak_o | pu_vweak_o) & pp_d) == '0);

  // R9
  off_no_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pu_strong_o | pu_weak_o | pu_vweak_o) & off_d) == '0);
endmodule

bind qbio_port qbio_port_chk #(.NPINS(NPINS)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .latch_i(latch_i),
  .slew_i(slew_i), .pad_i(pad_i), .pd_en_o(pd_en_o),
  .pu_strong_o(pu_strong_o), .pu_weak_o(pu_weak_o),
  .pu_vweak_o(pu_vweak_o), .slew_o(slew_o), .rd_o(rd_o)
);

// File: tb/qbio_port_tb.sv
module qbio_port_tb_top;
  localparam int N = 8;

  logic         clk = 0;
  logic         rst_n = 0;
  logic [2*N-1:0] mode_i = '0;
  logic [N-1:0] latch_i = '1, slew_i = '0, pad_i = '1;
  logic [N-1:0] pd_en_o, pu_strong_o, pu_weak_o, pu_vweak_o, slew_o, rd_o;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  int m_mode [N];
  int m_lat  [N];
  int m_slew [N];
  int m_s1   [N];
  int m_s2   [N];
  int m_cnt  [N];

  always #5 clk = ~clk;

  qbio_port #(.NPINS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .latch_i(latch_i),
    .slew_i(slew_i), .pad_i(pad_i), .pd_en_o(pd_en_o),
    .pu_strong_o(pu_strong_o), .pu_weak_o(pu_weak_o),
    .pu_vweak_o(pu_vweak_o), .slew_o(slew_o), .rd_o(rd_o)
  );

  always @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (!rst_n) begin
        m_mode[i] = 0; m_lat[i] = 1; m_slew[i] = 0;
        m_s1[i] = 1; m_s2[i] = 1; m_cnt[i] = 0;
      end else begin
        int nm, nl;
        nm = int'(mode_i[2*i +: 2]);
        nl = int'(latch_i[i]);
        if (nm == 0 && nl == 1 && m_lat[i] == 0) m_cnt[i] = 2;
        else if (nm == 0 && nl == 1 && m_cnt[i] > 0) m_cnt[i] = m_cnt[i] - 1;
        else m_cnt[i] = 0;
        m_mode[i] = nm; m_lat[i] = nl; m_slew[i] = int'(slew_i[i]);
        m_s2[i] = m_s1[i]; m_s1[i] = int'(pad_i[i]);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected<=20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(string tag, logic [N-1:0] got, logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b (cycle %0d)", tag, got, exp, cycles);
    end
  endtask

  task automatic compare_all();
    logic [N-1:0] e_pd, e_st, e_wk, e_vw, e_sl, e_rd;
    for (int i = 0; i < N; i++) begin
      e_pd[i] = (m_mode[i] != 2) && (m_lat[i] == 0);
      e_vw[i] = (m_mode[i] == 0) && (m_lat[i] == 1);
      e_wk[i] = (m_mode[i] == 0) && (m_lat[i] == 1) && (m_s2[i] == 1);
      e_st[i] = (m_lat[i] == 1) &&
                ((m_mode[i] == 1) || (m_mode[i] == 0 && m_cnt[i] > 0));
      e_sl[i] = (m_slew[i] == 1);
      e_rd[i] = (m_s2[i] == 1);
    end
    chk("R2 pull-down", pd_en_o, e_pd);
    chk("R3/R8/R9 very weak", pu_vweak_o, e_vw);
    chk("R4/R8/R9 weak", pu_weak_o, e_wk);
    chk("R5/R8/R9 strong", pu_strong_o, e_st);
    chk("R7 slew", slew_o, e_sl);
    chk("R6 readback", rd_o, e_rd);
  endtask

  task automatic tick();
    @(negedge clk);
    compare_all();
  endtask

  function automatic logic [2*N-1:0] all_mode(logic [1:0] m);
    logic [2*N-1:0] v;
    for (int i = 0; i < N; i++) v[2*i +: 2] = m;
    return v;
  endfunction

  initial begin
    logic [31:0] lfsr;
    lfsr = 32'h1d2c3b4a;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 reset pd", pd_en_o, '0);
    chk("R1 reset vweak", pu_vweak_o, '1);
    chk("R1 reset weak", pu_weak_o, '1);
    chk("R1 reset strong", pu_strong_o, '0);
    chk("R1 reset rd", rd_o, '1);
    chk("R1 reset slew", slew_o, '0);
    rst_n = 1;
    tick();

    // R5 boost on pin 0 in quasi-bidirectional mode
    latch_i = 8'hFE; pad_i = 8'hFE;
    tick(); tick();
    chk("R2 qb latch0 pd", pd_en_o, 8'h01);
    latch_i = 8'hFF; pad_i = 8'hFF;
    tick(); chk("R5 boost cycle1", pu_strong_o, 8'h01);
    tick(); chk("R5 boost cycle2", pu_strong_o, 8'h01);
    tick(); chk("R5 boost ended", pu_strong_o, 8'h00);

    // R4 outside pull-down turns weak off after sync
    pad_i = 8'hF7;
    tick(); tick();
    tick(); chk("R4 weak off under outside low", pu_weak_o, 8'hF7);
    chk("R6 readback sees low", rd_o, 8'hF7);
    pad_i = 8'hFF; tick(); tick(); tick();

    // R5 boost cut short by mode change
    latch_i = 8'hFD; tick();
    latch_i = 8'hFF; tick();
    mode_i = 16'h0004; tick();
    chk("R5 boost stops on mode change", pu_strong_o, 8'h02);
    tick();
    chk("R8 push-pull strong follows latch", pu_strong_o, 8'h02);
    chk("R8 push-pull no soft pulls", pu_vweak_o, 8'hFD);
    mode_i = '0; tick(); tick();
    chk("R5 no boost re-entering with latch1", pu_strong_o, 8'h00);

    // R8 push-pull
    mode_i = all_mode(2'b01); latch_i = 8'hA5; tick(); tick();
    chk("R8 pp strong", pu_strong_o, 8'hA5);
    chk("R8 pp pd", pd_en_o, 8'h5A);
    chk("R8 pp weak", pu_weak_o, 8'h00);

    // R9 input-only
    mode_i = all_mode(2'b10); latch_i = 8'h3C; pad_i = 8'h96; tick(); tick(); tick();
    chk("R9 input-only pd", pd_en_o, 8'h00);
    chk("R9 input-only pulls", pu_strong_o | pu_weak_o | pu_vweak_o, 8'h00);
    chk("R6 readback input-only", rd_o, 8'h96);

    // R9 open-drain
    mode_i = all_mode(2'b11); latch_i = 8'h0F; latch_i = 8'h0F; tick();
    latch_i = 8'hFF; tick(); tick();
    chk("R9 open-drain pulls", pu_strong_o | pu_weak_o | pu_vweak_o, 8'h00);
    chk("R9 open-drain pd", pd_en_o, 8'h00);

    // R7 slew per pin
    slew_i = 8'h5A; tick(); tick();
    chk("R7 slew select", slew_o, 8'h5A);

    // Mixed pseudo-random stimulus
    for (int k = 0; k < 600; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (lfsr[3:0] == 4'h0) mode_i = {lfsr[31:24], lfsr[15:8]};
      latch_i = lfsr[23:16] | lfsr[7:0];
      pad_i   = lfsr[30:23];
      if (lfsr[5]) slew_i = lfsr[12:5];
      tick();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule